// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns a programmed mode word and a stream of start, stop and mask strobes into the per-cycle column addresses and data-timing qualifiers of a synchronous DRAM burst. A mode write loads the burst length, the address ordering and the read latency. Each read or write start then runs a burst from the given column. The block steps the column through the programmed order and raises a burst-active flag for every beat. On reads, it delays a data-valid flag by the programmed latency and gates an output-enable with the read mask. On writes, it gates a write-enable with the write mask in the same cycle.

The block sits behind a command decoder. Command decoding, bank timing, refresh and the physical pins are handled elsewhere. Starts and stops are taken at the clock edge that samples them. Outputs are registered, except for `wrEn`, which follows `maskIn` in the same cycle. Beat 0 appears in the cycle that follows the accepted start.

Top module: `sdr_burst_seq`

## Requirements
- R1: After reset the mode is one-beat bursts, sequential order and latency 2. `cmdReady` is 1, and `colValid`, `rdValid`, `rdOutEn` and `wrEn` are 0. The mode word holds the length code in bits 2:0, with 000, 001, 010 and 011 giving 1, 2, 4 and 8 beats and 111 giving a full page. Bit 3 selects interleaved order. Bits 6:4 equal to 011 select latency 3; any other value selects latency 2.
- R2: A mode write accepted at an edge drives `cmdReady` low for the two cycles that follow. Starts, stops and mode writes sampled while `cmdReady` is low are ignored.
- R3: In sequential order, beat i addresses the column `base + (off + i) mod BL`, where `base` is the start column rounded down to a multiple of BL and `off` is the start column modulo BL. `colValid` is high for exactly BL cycles, beginning in the cycle after the start.
- R4: In interleaved order (lengths 2, 4 and 8), beat i addresses `base + (off XOR i)`.
- R5: A full-page burst steps sequentially and wraps from the last column of the page to column 0. It ends only on a stop or a new start.
- R6: `rdValid` is high in the cycle that lies L cycles after each read beat's cycle, where L is the programmed latency (2 or 3).
- R7: `wrEn` equals `colValid` AND write-burst AND NOT `maskIn` in the same cycle, so the write mask has zero latency.
- R8: `maskIn` held high in cycle c forces `rdOutEn` low in cycle c+2. In every other cycle, `rdOutEn` equals `rdValid`.
- R9: An accepted stop ends a burst of any length. `colValid` is low from the next cycle on, while read beats that were already issued still produce `rdValid`.
- R10: A start accepted during a burst begins the new burst at once. Priority is read start, then write start, then stop. A mode write sampled during an active burst is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| modeWr | input | 1 | Load the mode word |
| modeWord | input | 7 | Length, order and latency fields |
| rdStart | input | 1 | Begin a read burst |
| wrStart | input | 1 | Begin a write burst |
| burstStop | input | 1 | End the active burst |
| startCol | input | COL_W | Start column for a start strobe |
| maskIn | input | 1 | Per-beat data mask |
| colAddr | output | COL_W | Column of the current beat |
| colValid | output | 1 | A burst beat is active this cycle |
| rdValid | output | 1 | Read data valid after the latency |
| rdOutEn | output | 1 | Read output enable after the mask |
| wrEn | output | 1 | Write beat enable after the mask |
| cmdReady | output | 1 | Commands are accepted this cycle |

## Verification
Two functions can fall in the same cycle. A write burst may start while read beats from an interrupted read are still in the latency pipeline. The bench provokes this by cutting a read burst short with a write start, and it expects the tail of `rdValid` to overlap the new write's `wrEn` and column sequence cycle by cycle. The second overlap is a read mask that lands two cycles ahead of a late read beat while a stop is also pending. The bench checks it by comparing each cycle of `rdOutEn` against the predicted valid window with the masked cycle removed.

// File: rtl/sdr_seq_pkg.sv
`timescale 1ns/1ps
package sdr_seq_pkg;
  localparam logic [2:0] LEN_PAGE = 3'b111;
  localparam logic [2:0] CL_THREE = 3'b011;
  localparam int RD_PIPE_D  = 3;  // deepest read latency
  localparam int RD_MSK_LAT = 2;  // read mask delay

  // strobes and mode fields from control to datapath
  typedef struct packed {
    logic       load;
    logic       step;
    logic       interleave;
    logic [2:0] lenCode;
  } seqCtl_t;
endpackage

// File: rtl/sdr_seq_dp.sv
`timescale 1ns/1ps
module sdr_seq_dp
  import sdr_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  input  logic [COL_W-1:0] startCol,
  output logic [COL_W-1:0] colAddr,
  output logic             atLast
);
  logic [COL_W-1:0] startReg;
  logic [COL_W-1:0] beatCnt;
  logic [COL_W-1:0] lenMask;
  logic [COL_W-1:0] seqCol;
  logic [COL_W-1:0] ilvCol;
  logic [COL_W-1:0] pickCol;
  logic             fullPage;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startReg <= '0;
      beatCnt  <= '0;
    end else if (ctl.load) begin
      startReg <= startCol;
      beatCnt  <= '0;
    end else if (ctl.step) begin
      beatCnt  <= beatCnt + COL_W'(1);
    end
  end

  always_comb begin
    fullPage = (ctl.lenCode == LEN_PAGE);
    case (ctl.lenCode)
      3'b001:   lenMask = COL_W'(1);
      3'b010:   lenMask = COL_W'(3);
      3'b011:   lenMask = COL_W'(7);
      LEN_PAGE: lenMask = '1;
      default:  lenMask = '0;
    endcase
  end

  assign seqCol  = startReg + beatCnt;
  assign ilvCol  = startReg ^ beatCnt;
  assign pickCol = (ctl.interleave && !fullPage) ? ilvCol : seqCol;
  assign colAddr = (startReg & ~lenMask) | (pickCol & lenMask);
  assign atLast  = !fullPage && ((beatCnt & lenMask) == lenMask);
endmodule

// File: rtl/sdr_seq_ctrl.sv
`timescale 1ns/1ps
module sdr_seq_ctrl
  import sdr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWr,
  input  logic [6:0] modeWord,
  input  logic       rdStart,
  input  logic       wrStart,
  input  logic       burstStop,
  input  logic       maskIn,
  input  logic       atLast,
  output seqCtl_t    ctl,
  output logic       colValid,
  output logic       rdValid,
  output logic       rdOutEn,
  output logic       wrEn,
  output logic       cmdReady
);
  logic [2:0] lenReg;
  logic       ilvReg;
  logic       clThree;
  logic       busy;
  logic       isWr;
  logic [1:0] holdCnt;
  logic       doMode, doRd, doWr, doStart, doStop;
  logic       readBeat;
  logic [RD_PIPE_D-1:0]  rdPipe;
  logic [RD_MSK_LAT-1:0] mskPipe;

  assign cmdReady = (holdCnt == 2'd0);
  assign doMode   = cmdReady && modeWr && !busy;
  assign doRd     = cmdReady && !doMode && rdStart;
  assign doWr     = cmdReady && !doMode && !rdStart && wrStart;
  assign doStart  = doRd || doWr;
  assign doStop   = cmdReady && !doMode && !doStart && burstStop;
  assign readBeat = busy && !isWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg  <= 3'b000;
      ilvReg  <= 1'b0;
      clThree <= 1'b0;
      holdCnt <= 2'd0;
    end else if (doMode) begin
      lenReg  <= modeWord[2:0];
      ilvReg  <= modeWord[3];
      clThree <= (modeWord[6:4] == CL_THREE);
      holdCnt <= 2'd2;
    end else if (holdCnt != 2'd0) begin
      holdCnt <= holdCnt - 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      isWr <= 1'b0;
    end else if (doStart) begin
      busy <= 1'b1;
      isWr <= doWr;
    end else if (doStop || (busy && atLast)) begin
      busy <= 1'b0;
    end
  end

  // read-valid delay line, one stage per latency cycle
  generate
    for (genvar s = 0; s < RD_PIPE_D; s++) begin : g_rdStage
      always_ff @(posedge clk) begin
        if (!rstN) rdPipe[s] <= 1'b0;
        else if (s == 0) rdPipe[s] <= readBeat;
        else rdPipe[s] <= rdPipe[(s == 0) ? 0 : s-1];
      end
    end
    for (genvar m = 0; m < RD_MSK_LAT; m++) begin : g_mskStage
      always_ff @(posedge clk) begin
        if (!rstN) mskPipe[m] <= 1'b0;
        else if (m == 0) mskPipe[m] <= maskIn;
        else mskPipe[m] <= mskPipe[(m == 0) ? 0 : m-1];
      end
    end
  endgenerate

  assign ctl.load       = doStart;
  assign ctl.step       = busy;
  assign ctl.interleave = ilvReg;
  assign ctl.lenCode    = lenReg;

  assign colValid = busy;
  assign rdValid  = clThree ? rdPipe[2] : rdPipe[1];
  assign rdOutEn  = rdValid && !mskPipe[RD_MSK_LAT-1];
  assign wrEn     = busy && isWr && !maskIn;
endmodule

// File: rtl/sdr_burst_seq.sv
`timescale 1ns/1ps
module sdr_burst_seq
  import sdr_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWr,
  input  logic [6:0]       modeWord,
  input  logic             rdStart,
  input  logic             wrStart,
  input  logic             burstStop,
  input  logic [COL_W-1:0] startCol,
  input  logic             maskIn,
  output logic [COL_W-1:0] colAddr,
  output logic             colValid,
  output logic             rdValid,
  output logic             rdOutEn,
  output logic             wrEn,
  output logic             cmdReady
);
  seqCtl_t ctl;
  logic    atLast;

  sdr_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .modeWord(modeWord),
    .rdStart(rdStart), .wrStart(wrStart), .burstStop(burstStop),
    .maskIn(maskIn), .atLast(atLast), .ctl(ctl), .colValid(colValid),
    .rdValid(rdValid), .rdOutEn(rdOutEn), .wrEn(wrEn), .cmdReady(cmdReady)
  );

  sdr_seq_dp #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startCol(startCol),
    .colAddr(colAddr), .atLast(atLast)
  );
endmodule

// File: rtl/sdr_burst_seq_chk.sv
`timescale 1ns/1ps
module sdr_burst_seq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             modeWr,
  input logic             rdStart,
  input logic             wrStart,
  input logic             burstStop,
  input logic [COL_W-1:0] startCol,
  input logic             maskIn,
  input logic [COL_W-1:0] colAddr,
  input logic             colValid,
  input logic             rdValid,
  input logic             rdOutEn,
  input logic             wrEn,
  input logic             cmdReady
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rstN) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_HOLDOFF_TWO: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && cmdReady && !colValid) |=> (!cmdReady ##1 !cmdReady)); // R2
  AST_HOLDOFF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cmdReady |-> !colValid); // R2
  AST_START_COL: assert property (@(posedge clk) disable iff (!rstN)
    ((rdStart || wrStart) && cmdReady && !(modeWr && !colValid))
      |=> (colValid && colAddr == $past(startCol))); // R3
  AST_WR_MASK_NOW: assert property (@(posedge clk) disable iff (!rstN)
    maskIn |-> !wrEn); // R7
  AST_WR_IN_BURST: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> colValid); // R7
  AST_RD_MASK_LATE: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 2'd2 && $past(maskIn, 2)) |-> !rdOutEn); // R8
  AST_OE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    rdOutEn |-> rdValid); // R8
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (burstStop && cmdReady && !rdStart && !wrStart && !modeWr) |=> !colValid); // R9
  AST_READ_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (rdStart && wrStart && cmdReady && colValid) |=> !wrEn); // R10
endmodule

bind sdr_burst_seq sdr_burst_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rstN(rstN), .modeWr(modeWr), .rdStart(rdStart),
  .wrStart(wrStart), .burstStop(burstStop), .startCol(startCol),
  .maskIn(maskIn), .colAddr(colAddr), .colValid(colValid),
  .rdValid(rdValid), .rdOutEn(rdOutEn), .wrEn(wrEn), .cmdReady(cmdReady)
);

// File: tb/sim_sdr_burst_seq.sv
`timescale 1ns/1ps
module sim_sdr_burst_seq;
  localparam int COL_W = 10;
  localparam int PAGE  = 1 << COL_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeWr = 1'b0;
  logic [6:0] modeWord = '0;
  logic rdStart = 1'b0, wrStart = 1'b0, burstStop = 1'b0, maskIn = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [COL_W-1:0] colAddr;
  logic colValid, rdValid, rdOutEn, wrEn, cmdReady;

  int nChk = 0;
  int nErr = 0;

  always #2.5 clk = ~clk;

  sdr_burst_seq #(.COL_W(COL_W)) u0 (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .modeWord(modeWord),
    .rdStart(rdStart), .wrStart(wrStart), .burstStop(burstStop),
    .startCol(startCol), .maskIn(maskIn), .colAddr(colAddr),
    .colValid(colValid), .rdValid(rdValid), .rdOutEn(rdOutEn),
    .wrEn(wrEn), .cmdReady(cmdReady)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int expAddr(input int start, input int i, input int len, input int ilv);
    int bl, base, off;
    bl   = (len == 7) ? PAGE : (1 << len);
    base = (start / bl) * bl;
    off  = start % bl;
    if (ilv != 0 && len != 7) return base + (off ^ (i % bl));
    return base + ((off + i) % bl);
  endfunction

  task automatic setMode(input int len, input int ilv, input int cl);
    modeWord = 7'(cl * 16 + ilv * 8 + len);
    modeWr = 1'b1;
    tick;
    modeWr = 1'b0;
    tick;
    tick;
  endtask

  // start a burst in window 0, then check every later window
  task automatic runBurst(input bit rd, input int start, input int len, input int ilv,
                          input int cl, input int maskW, input int stopW, input string req);
    int bl, nb;
    bit expV, expR;
    bl = (len == 7) ? PAGE : (1 << len);
    nb = (stopW > 0 && stopW < bl) ? stopW : bl;
    startCol = COL_W'(start);
    rdStart = rd;
    wrStart = !rd;
    tick;
    rdStart = 1'b0;
    wrStart = 1'b0;
    for (int w = 1; w <= nb + cl + 2; w++) begin
      maskIn = (w == maskW);
      burstStop = (w == stopW);
      #1;
      expV = (w <= nb);
      chk(req, "colValid", int'(colValid), int'(expV));
      if (expV) chk(req, "colAddr", int'(colAddr), expAddr(start, w - 1, len, ilv));
      chk(req, "wrEn", int'(wrEn), int'(!rd && expV && w != maskW));
      expR = rd && (w - cl >= 1) && (w - cl <= nb);
      chk(req, "rdValid", int'(rdValid), int'(expR));
      chk(req, "rdOutEn", int'(rdOutEn), int'(expR && (w - 2 != maskW)));
      tick;
    end
    maskIn = 1'b0;
    burstStop = 1'b0;
  endtask

  task automatic t_reset;
    rstN = 1'b0;
    repeat (3) tick;
    chk("R1", "cmdReady", int'(cmdReady), 1);
    chk("R1", "colValid", int'(colValid), 0);
    chk("R1", "rdValid", int'(rdValid), 0);
    chk("R1", "rdOutEn", int'(rdOutEn), 0);
    chk("R1", "wrEn", int'(wrEn), 0);
    rstN = 1'b1;
    tick;
    runBurst(1'b1, 5, 0, 0, 2, -1, -1, "R1");
  endtask

  task automatic t_holdoff;
    modeWord = 7'(2 * 16 + 0 * 8 + 1);
    modeWr = 1'b1;
    tick;
    modeWr = 1'b0;
    chk("R2", "cmdReady w1", int'(cmdReady), 0);
    rdStart = 1'b1;
    startCol = COL_W'(3);
    tick;
    chk("R2", "cmdReady w2", int'(cmdReady), 0);
    chk("R2", "colValid w2", int'(colValid), 0);
    tick;
    rdStart = 1'b0;
    chk("R2", "cmdReady w3", int'(cmdReady), 1);
    chk("R2", "colValid w3", int'(colValid), 0);
    runBurst(1'b1, 3, 1, 0, 2, -1, -1, "R2");
  endtask

  task automatic t_seqRead;
    setMode(2, 0, 3);
    runBurst(1'b1, 6, 2, 0, 3, -1, -1, "R3 R6");
  endtask

  task automatic t_seqWrite;
    setMode(3, 0, 3);
    runBurst(1'b0, 13, 3, 0, 3, 3, -1, "R3 R7");
  endtask

  task automatic t_ilvRead;
    setMode(3, 1, 2);
    runBurst(1'b1, 5, 3, 1, 2, 4, -1, "R4 R8");
  endtask

  task automatic t_ilvWrite;
    setMode(1, 1, 2);
    runBurst(1'b0, 3, 1, 1, 2, 1, -1, "R4 R7");
  endtask

  task automatic t_fullPage;
    setMode(7, 0, 2);
    runBurst(1'b1, 1020, 7, 0, 2, 5, 10, "R5 R9");
  endtask

  task automatic t_stopDrain;
    setMode(3, 0, 3);
    runBurst(1'b1, 2, 3, 0, 3, -1, 3, "R9 R6");
  endtask

  task automatic t_interrupt;
    setMode(3, 0, 3);
    startCol = COL_W'(8);
    rdStart = 1'b1;
    tick;
    rdStart = 1'b0;
    #1 chk("R10", "colAddr w1", int'(colAddr), 8);
    tick;
    modeWord = 7'(2 * 16);
    modeWr = 1'b1;
    #1 chk("R10", "colAddr w2", int'(colAddr), 9);
    tick;
    modeWr = 1'b0;
    chk("R10", "cmdReady after busy mode write", int'(cmdReady), 1);
    chk("R10", "colAddr w3", int'(colAddr), 10);
    startCol = COL_W'(40);
    wrStart = 1'b1;
    burstStop = 1'b1;
    tick;
    wrStart = 1'b0;
    burstStop = 1'b0;
    for (int w = 4; w <= 12; w++) begin
      #1;
      chk("R10", "colValid", int'(colValid), int'(w <= 11));
      if (w <= 11) chk("R10", "colAddr", int'(colAddr), expAddr(40, w - 4, 3, 0));
      chk("R10", "wrEn", int'(wrEn), int'(w <= 11));
      chk("R10", "rdValid tail", int'(rdValid), int'(w <= 6));
      tick;
    end
  endtask

  task automatic t_priority;
    startCol = COL_W'(0);
    rdStart = 1'b1;
    wrStart = 1'b1;
    tick;
    rdStart = 1'b0;
    wrStart = 1'b0;
    burstStop = 1'b1;
    #1;
    chk("R10", "colValid both starts", int'(colValid), 1);
    chk("R10", "wrEn both starts", int'(wrEn), 0);
    tick;
    burstStop = 1'b0;
    chk("R10", "colValid after stop", int'(colValid), 0);
    tick;
    tick;
    chk("R10", "rdValid proves read", int'(rdValid), 1);
    tick;
    tick;
  endtask

  initial begin
    #(5.0 * 200000);
    nErr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_holdoff;
    t_seqRead;
    t_seqWrite;
    t_ilvRead;
    t_ilvWrite;
    t_fullPage;
    t_stopDrain;
    t_interrupt;
    t_priority;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule